// File: doc/BRIEF.md
# DLL Delay-Code Controller

This block is the digital half of a delay-locked loop that sets the delay of strobe delay chains in an external memory interface. A phase comparator outside the block reports, once per enabled sample, whether the chain delay should grow or shrink. The block keeps a 6-bit delay code in a saturating up/down counter and steps it by one per enabled sample. It tells the delay chains when a new code is worth loading, and it raises a ready flag once the loop has had its full settling time after reset.

A frequency-mode input, captured only while reset is held, sets the code range. The lower four modes use the full 6-bit range. The upper four modes use only 5 bits, with the top bit held at zero. A separate offset stage takes the live code and either adds or subtracts a 6-bit user offset. The result is clamped to the range of the current mode, which gives an adjusted code for strobe pins that need a trimmed delay.

Top module: `dll_code_ctrl`

## Requirements
- R1: While reset is held, the code loads the midpoint of the range of the mode present at that time: 32 for modes 0 to 3, 16 for modes 4 to 7. The update strobe is low during reset.
- R2: On each clock with `cmp_en` high, the code steps up by one when `cmp_up` is 1 and down by one when `cmp_up` is 0. The change is visible on `code_out` after that clock edge.
- R3: The code saturates. It stays at 0 on a down step, and it stays at the mode maximum (63 in modes 0 to 3, 31 in modes 4 to 7) on an up step. It never wraps.
- R4: With `cmp_en` low, `cmp_up` has no effect on the code, and the cycle does not count as a sample for the update strobe.
- R5: `ready` goes low on reset from either `rst_core` or `rst_pin`. It stays low until 1280 clock edges without reset have passed and is high from the 1280th such edge on.
- R6: `upd_strobe` is high for exactly one cycle, in the cycle after every 8th enabled sample counted from reset. It rises only if the code after that sample differs from the code at the previous strobe, or from the reset midpoint if there has been no strobe.
- R7: `freq_mode` is sampled only during reset. A mode of 4 or more keeps `code_out[5]` at 0. Changing `freq_mode` outside reset does not change the range.
- R8: With `ofs_sub` at 0, `code_adj` equals the code plus `ofs_val`, clamped to the mode maximum.
- R9: With `ofs_sub` at 1, `code_adj` equals the code minus `ofs_val`, clamped at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_core | input | 1 | Synchronous active-high reset from internal logic |
| rst_pin | input | 1 | Synchronous active-high reset from an external pin |
| freq_mode | input | 3 | Frequency mode, captured during reset |
| cmp_en | input | 1 | Comparator sample enable |
| cmp_up | input | 1 | Comparator result: 1 = step up, 0 = step down |
| ofs_val | input | 6 | Offset magnitude |
| ofs_sub | input | 1 | 0 = add offset, 1 = subtract offset |
| code_out | output | 6 | Live delay code |
| code_adj | output | 6 | Offset-adjusted delay code |
| upd_strobe | output | 1 | One-cycle pulse: load new code into delay chains |
| ready | output | 1 | Settling time since last reset has elapsed |

## Verification
The bench drives the counter into both rails in both range classes. A counter that wraps would jump from 63 to 0, from 0 to 63, or from 31 into the upper half. It checks `ready` on the 1279th and the 1280th edge after each reset source, so an off-by-one settling counter, or one that ignores the pin reset, shows up as a flag that is early, late or stuck. For the strobe it counts 8 samples with idle cycles in between and then a window that ends on the starting code. A strobe that counts disabled cycles, or that ignores the code-changed condition, pulses in the wrong cycle or when it should not. It also changes the mode after reset and drives the offset both past the upper rail and below zero, so a live mode input or a wrapping offset sum gives a wrong code.

// File: rtl/dll_pkg.sv
package dll_pkg;

   // Largest code for a range class; the narrow class loses the top bit.
   function automatic int unsigned code_limit(input int unsigned w, input logic narrow);
      return narrow ? ((32'd1 << (w - 1)) - 1) : ((32'd1 << w) - 1);
   endfunction

   // Reset midpoint for a range class.
   function automatic int unsigned code_mid(input int unsigned w, input logic narrow);
      return narrow ? (32'd1 << (w - 2)) : (32'd1 << (w - 1));
   endfunction

endpackage

// File: rtl/dll_updn_counter.sv
module dll_updn_counter #(
   parameter int CODE_W      = 6,
   parameter int MODE_W      = 3,
   parameter int NARROW_FROM = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_W-1:0] freq_mode,
   input  logic              cmp_en,
   input  logic              cmp_up,
   output logic [CODE_W-1:0] code,
   output logic [CODE_W-1:0] code_next,
   output logic [CODE_W-1:0] limit
);
   localparam logic [CODE_W-1:0] LIM_WIDE = CODE_W'(dll_pkg::code_limit(CODE_W, 1'b0));
   localparam logic [CODE_W-1:0] LIM_NARR = CODE_W'(dll_pkg::code_limit(CODE_W, 1'b1));
   localparam logic [CODE_W-1:0] MID_WIDE = CODE_W'(dll_pkg::code_mid(CODE_W, 1'b0));
   localparam logic [CODE_W-1:0] MID_NARR = CODE_W'(dll_pkg::code_mid(CODE_W, 1'b1));

   if (CODE_W < 3) begin : g_bad_width
      $error("dll_updn_counter: CODE_W must be at least 3");
   end
   if (NARROW_FROM >= (1 << MODE_W)) begin : g_bad_mode
      $error("dll_updn_counter: NARROW_FROM outside mode range");
   end

   logic              narrow_q;
   logic              rst_narrow;
   logic [CODE_W-1:0] code_q;

   assign rst_narrow = (freq_mode >= MODE_W'(NARROW_FROM));
   assign limit      = narrow_q ? LIM_NARR : LIM_WIDE;

   always_comb begin
      if (rst)
         code_next = rst_narrow ? MID_NARR : MID_WIDE;
      else if (cmp_en && cmp_up && (code_q != limit))
         code_next = code_q + CODE_W'(1);
      else if (cmp_en && !cmp_up && (code_q != '0))
         code_next = code_q - CODE_W'(1);
      else
         code_next = code_q;
   end

   always_ff @(posedge clk) begin
      code_q <= code_next;
      if (rst) narrow_q <= rst_narrow;
   end

   // Top bit forced low in the narrow class; the rest pass straight through.
   for (genvar i = 0; i < CODE_W; i++) begin : g_out
      if (i == CODE_W - 1) begin : g_top
         assign code[i] = code_q[i] & ~narrow_q;
      end else begin : g_low
         assign code[i] = code_q[i];
      end
   end

   a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
      cmp_en |=> (code_q == $past(code_q)) || (code_q == $past(code_q) + CODE_W'(1))
                 || (code_q == $past(code_q) - CODE_W'(1)));
   a_r3_top_rail: assert property (@(posedge clk) disable iff (rst)
      (cmp_en && cmp_up && code_q == limit) |=> code_q == $past(code_q));
   a_r3_bottom_rail: assert property (@(posedge clk) disable iff (rst)
      (cmp_en && !cmp_up && code_q == '0) |=> code_q == '0);
   a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      !cmp_en |=> $stable(code_q));
   a_r7_narrow_top: assert property (@(posedge clk) disable iff (rst)
      narrow_q |-> !code_q[CODE_W-1]);
   a_r7_mode_held: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> $stable(narrow_q));
endmodule

// File: rtl/dll_update_gen.sv
module dll_update_gen #(
   parameter int CODE_W      = 6,
   parameter int UPD_SAMPLES = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmp_en,
   input  logic [CODE_W-1:0] code_next,
   output logic              strobe
);
   localparam int SW = $clog2(UPD_SAMPLES);

   if (UPD_SAMPLES < 2) begin : g_bad_samples
      $error("dll_update_gen: UPD_SAMPLES must be at least 2");
   end

   logic [SW-1:0]     samp_q;
   logic [CODE_W-1:0] last_q;
   logic              wrap;
   logic              fire;

   assign wrap = cmp_en && (samp_q == SW'(UPD_SAMPLES - 1));
   assign fire = wrap && (code_next != last_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         samp_q <= '0;
         last_q <= code_next;
         strobe <= 1'b0;
      end else begin
         strobe <= fire;
         if (cmp_en) samp_q <= wrap ? '0 : samp_q + SW'(1);
         if (fire)   last_q <= code_next;
      end
   end

   a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
      strobe |=> !strobe);
   a_r6_after_wrap: assert property (@(posedge clk) disable iff (rst)
      $rose(strobe) |-> $past(wrap));
endmodule

// File: rtl/dll_settle_timer.sv
module dll_settle_timer #(
   parameter int SETTLE_CYCLES = 1280
) (
   input  logic clk,
   input  logic rst,
   output logic ready
);
   localparam int CW = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CW-1:0] DONE = CW'(SETTLE_CYCLES);

   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("dll_settle_timer: SETTLE_CYCLES must be positive");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                cnt_q <= '0;
      else if (cnt_q != DONE) cnt_q <= cnt_q + CW'(1);
   end

   assign ready = (cnt_q == DONE);

   a_r5_ready_sticky: assert property (@(posedge clk) disable iff (rst)
      ready |=> ready);
   a_r5_count_moves: assert property (@(posedge clk) disable iff (rst)
      !ready |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/dll_offset_stage.sv
module dll_offset_stage #(
   parameter int CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] limit,
   input  logic [CODE_W-1:0] ofs,
   input  logic              sub,
   output logic [CODE_W-1:0] adj
);
   logic [CODE_W:0] sum;

   assign sum = {1'b0, code} + {1'b0, ofs};

   always_comb begin
      if (sub)
         adj = (ofs > code) ? '0 : code - ofs;
      else if (sum > {1'b0, limit})
         adj = limit;
      else
         adj = sum[CODE_W-1:0];
   end

   a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
      adj <= limit);
   a_r9_sub_not_above: assert property (@(posedge clk) disable iff (rst)
      sub |-> adj <= code);
endmodule

// File: rtl/dll_code_ctrl.sv
module dll_code_ctrl #(
   parameter int CODE_W        = 6,
   parameter int MODE_W        = 3,
   parameter int NARROW_FROM   = 4,
   parameter int UPD_SAMPLES   = 8,
   parameter int SETTLE_CYCLES = 1280
) (
   input  logic              clk,
   input  logic              rst_core,
   input  logic              rst_pin,
   input  logic [MODE_W-1:0] freq_mode,
   input  logic              cmp_en,
   input  logic              cmp_up,
   input  logic [CODE_W-1:0] ofs_val,
   input  logic              ofs_sub,
   output logic [CODE_W-1:0] code_out,
   output logic [CODE_W-1:0] code_adj,
   output logic              upd_strobe,
   output logic              ready
);
   logic              rst;
   logic [CODE_W-1:0] code_next;
   logic [CODE_W-1:0] limit;

   assign rst = rst_core | rst_pin;

   dll_updn_counter #(.CODE_W(CODE_W), .MODE_W(MODE_W), .NARROW_FROM(NARROW_FROM)) u_cnt (
      .clk(clk), .rst(rst), .freq_mode(freq_mode), .cmp_en(cmp_en), .cmp_up(cmp_up),
      .code(code_out), .code_next(code_next), .limit(limit));

   dll_update_gen #(.CODE_W(CODE_W), .UPD_SAMPLES(UPD_SAMPLES)) u_upd (
      .clk(clk), .rst(rst), .cmp_en(cmp_en), .code_next(code_next), .strobe(upd_strobe));

   dll_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk(clk), .rst(rst), .ready(ready));

   dll_offset_stage #(.CODE_W(CODE_W)) u_ofs (
      .clk(clk), .rst(rst), .code(code_out), .limit(limit), .ofs(ofs_val),
      .sub(ofs_sub), .adj(code_adj));

   a_r1_no_strobe_in_reset: assert property (@(posedge clk)
      rst |=> !upd_strobe && !ready);
endmodule

// File: tb/sim_dll_code_ctrl.sv
module sim_dll_code_ctrl;
   logic       clk = 1'b0;
   logic       rst_core = 1'b1, rst_pin = 1'b0;
   logic [2:0] freq_mode = 3'd0;
   logic       cmp_en = 1'b0, cmp_up = 1'b0;
   logic [5:0] ofs_val = 6'd0;
   logic       ofs_sub = 1'b0;
   logic [5:0] code_out, code_adj;
   logic       upd_strobe, ready;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   // bench model state
   int m_code, m_lim, m_samp, m_last;

   always #10 clk = ~clk;  // 50 MHz

   dll_code_ctrl u0 (.clk(clk), .rst_core(rst_core), .rst_pin(rst_pin), .freq_mode(freq_mode),
      .cmp_en(cmp_en), .cmp_up(cmp_up), .ofs_val(ofs_val), .ofs_sub(ofs_sub),
      .code_out(code_out), .code_adj(code_adj), .upd_strobe(upd_strobe), .ready(ready));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Reset from one source for one cycle, then release; checks R1.
   task automatic do_reset(input bit use_pin, input int mode);
      @(negedge clk);
      cmp_en = 1'b0;
      freq_mode = 3'(mode);
      if (use_pin) rst_pin = 1'b1; else rst_core = 1'b1;
      @(negedge clk);
      m_lim  = (mode >= 4) ? 31 : 63;
      m_code = (mode >= 4) ? 16 : 32;
      m_samp = 0;
      m_last = m_code;
      chk(code_out == 6'(m_code), "R1 reset midpoint", code_out, m_code);
      chk(!upd_strobe, "R1 strobe low in reset", upd_strobe, 0);
      chk(!ready, "R5 ready low in reset", ready, 0);
      rst_pin = 1'b0;
      rst_core = 1'b0;
   endtask

   // One sample cycle; the result is visible at the following negedge.
   task automatic step(input bit en, input bit up, input string req);
      bit wrap, exp_s;
      cmp_en = en;
      cmp_up = up;
      @(negedge clk);
      if (en && up && m_code != m_lim) m_code++;
      else if (en && !up && m_code != 0) m_code--;
      wrap  = en && (m_samp == 7);
      exp_s = wrap && (m_code != m_last);
      if (exp_s) m_last = m_code;
      if (en) m_samp = wrap ? 0 : m_samp + 1;
      chk(code_out == 6'(m_code), req, code_out, m_code);
      chk(upd_strobe == exp_s, "R6 strobe timing", upd_strobe, exp_s);
   endtask

   task automatic t_settle(input bit use_pin);
      do_reset(use_pin, 0);
      repeat (1279) @(negedge clk);
      chk(!ready, "R5 ready still low at 1279", ready, 0);
      @(negedge clk);
      chk(ready, "R5 ready high at 1280", ready, 1);
   endtask

   task automatic t_rails_wide;
      do_reset(1'b0, 0);
      step(1'b1, 1'b1, "R2 step up");
      step(1'b1, 1'b0, "R2 step down");
      for (int i = 0; i < 40; i++) step(1'b1, 1'b1, "R3 up to 63");
      chk(code_out == 6'd63, "R3 top rail 63", code_out, 63);
      for (int i = 0; i < 70; i++) step(1'b1, 1'b0, "R3 down to 0");
      chk(code_out == 6'd0, "R3 bottom rail 0", code_out, 0);
   endtask

   task automatic t_enable_gate;
      do_reset(1'b0, 2);
      for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R4 disabled hold");
      chk(code_out == 6'd32, "R4 code unchanged", code_out, 32);
      // 8 enabled ups mixed with idles: strobe after the 8th enabled one only
      for (int i = 0; i < 8; i++) begin
         step(1'b1, 1'b1, "R6 counted up");
         step(1'b0, 1'b0, "R4 idle between samples");
      end
      chk(m_last == 40, "R6 strobe fired once", m_last, 40);
      // 8 samples returning to 40: no strobe expected
      for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R6 window up");
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, "R6 window down, no strobe");
   endtask

   task automatic t_narrow;
      do_reset(1'b1, 5);
      freq_mode = 3'd0;  // must be ignored outside reset
      for (int i = 0; i < 20; i++) step(1'b1, 1'b1, "R7 narrow up");
      chk(code_out == 6'd31, "R7 narrow top 31", code_out, 31);
      chk(!code_out[5], "R7 bit5 zero", code_out[5], 0);
   endtask

   task automatic t_offset;
      do_reset(1'b0, 0);  // code 32
      ofs_sub = 1'b0; ofs_val = 6'd40; #1;
      chk(code_adj == 6'd63, "R8 add clamps 63", code_adj, 63);
      ofs_val = 6'd10; #1;
      chk(code_adj == 6'd42, "R8 add 32+10", code_adj, 42);
      ofs_sub = 1'b1; #1;
      chk(code_adj == 6'd22, "R9 sub 32-10", code_adj, 22);
      ofs_val = 6'd40; #1;
      chk(code_adj == 6'd0, "R9 sub clamps 0", code_adj, 0);
      do_reset(1'b0, 6);  // code 16, max 31
      ofs_sub = 1'b0; ofs_val = 6'd20; #1;
      chk(code_adj == 6'd31, "R8 narrow add clamps 31", code_adj, 31);
      ofs_val = 6'd5; #1;
      chk(code_adj == 6'd21, "R8 narrow add 16+5", code_adj, 21);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_settle(1'b0);
      t_settle(1'b1);
      t_rails_wide();
      t_enable_gate();
      t_narrow();
      t_offset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule